// File: doc/BRIEF.md
# Text-Mode Character Display Generator

This block turns a character screen into a one-bit pixel stream for a raster display. The screen is 80 character cells across and 40 down, and each cell is drawn from an 8-pixel-wide, 12-line-tall glyph. A host fills a screen buffer with 7-bit character codes through a write port. A separate load port installs glyph bitmaps into a font memory.

The raster side gives the block two strobes: one marks the last pixel clock of every scan line, and one, raised together with it, marks the last line of a frame. The block tracks the character column, the character row and the line within the glyph itself. For each cell it reads the character code, then reads the matching glyph byte. It shifts that byte out most-significant bit first, one pixel per clock. The two reads are started early enough that each new byte reaches the shifter exactly at the cell boundary.

A blank input forces the output to zero. Pixels beyond the 640th position of a line are dark, and so are lines beyond the 480th of a frame.

Top module: `text_char_gen`

## Requirements
- R1: While reset is held, and after it until the first end-of-line strobe, pix is 0.
- R2: For pixel position x on a scan line of text row r and glyph line g, the code is read from screen address r*80 + x/8. The glyph byte is read from font address code*12 + g. Bit 7 of that byte is the leftmost pixel of the cell and bit 0 the rightmost.
- R3: If the end-of-line strobe is sampled high at a rising edge, the pixel for position x (0 to 639) is on pix after the (x+3)-th rising edge that follows.
- R4: Positions 640 and beyond on a line give pix = 0, and the column counter never passes 79.
- R5: When blank is sampled high at a rising edge, pix is 0 after that edge.
- R6: Each end-of-line strobe moves to the next glyph line. After glyph line 11 the glyph line returns to 0 and the row advances by one.
- R7: Once glyph line 11 of row 39 has ended, every later line of the frame gives pix = 0.
- R8: An end-of-frame strobe, given together with an end-of-line strobe, makes the next line row 0, glyph line 0. This holds whether or not the frame has finished.
- R9: A screen-buffer write (scr_we, 12-bit address, 7-bit code) changes the glyph shown for that cell on lines fetched after the write.
- R10: A font write (font_we, 11-bit address code*12 + line, 8-bit row of pixels) changes that glyph line on lines fetched after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_end | input | 1 | High on the last pixel clock of each scan line |
| frame_end | input | 1 | High with line_end on the last line of a frame |
| blank | input | 1 | Forces the pixel output to 0 |
| scr_we | input | 1 | Screen buffer write enable |
| scr_waddr | input | 12 | Screen buffer write address, row*80 + column |
| scr_wdata | input | 7 | Character code to store |
| font_we | input | 1 | Font memory write enable |
| font_waddr | input | 11 | Font memory write address, code*12 + glyph line |
| font_wdata | input | 8 | Glyph line bits, bit 7 leftmost |
| pix | output | 1 | Registered monochrome pixel |

## Verification
Full-width lines are driven over a buffer filled with a varied code pattern and a font in which every byte differs. A wrong bit order, a wrong latency or a wrong address term each breaks many pixels at once. A sweep of short lines across all 480 glyph lines separates errors in the glyph-line and row carries from errors in horizontal alignment. Lines past the text area and early frame restarts exercise the vertical end conditions. Blank windows that start mid-cell and writes made between lines show that gating and memory updates apply at the right cycle.

// File: rtl/tc_pkg.sv
package tc_pkg;

  // One stage of the fetch pipeline: cell boundary marker and data-valid flag
  typedef struct packed {
    logic ld;
    logic act;
  } tc_stage_t;

endpackage

// File: rtl/tc_sdp_ram.sv
// Simple dual-port memory: one synchronous write port, one registered read port.
module tc_sdp_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tc_raster_ctr.sv
// Column, sub-pixel, glyph-line and row tracking driven by the raster strobes.
module tc_raster_ctr #(
  parameter int COLS    = 80,
  parameter int ROWS    = 40,
  parameter int CELL_H  = 12,
  parameter int GLYPH_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      line_end,
  input  logic                      frame_end,
  output logic [$clog2(COLS)-1:0]   col,
  output logic [$clog2(ROWS)-1:0]   row,
  output logic [$clog2(CELL_H)-1:0] gline,
  output logic                      cell_start,
  output logic                      fetch_ok,
  output logic                      v_done
);

  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int GL_W  = $clog2(CELL_H);
  localparam int SUB_W = $clog2(GLYPH_W);

  logic [SUB_W-1:0] sub;
  logic             h_done;

  // Horizontal: restart on the line strobe, stop after the last cell
  always_ff @(posedge clk) begin
    if (rst) begin
      sub    <= '0;
      col    <= '0;
      h_done <= 1'b1;
    end else if (line_end) begin
      sub    <= '0;
      col    <= '0;
      h_done <= 1'b0;
    end else if (!h_done) begin
      if (sub == SUB_W'(GLYPH_W - 1)) begin
        sub <= '0;
        if (col == COL_W'(COLS - 1)) h_done <= 1'b1;
        else                         col    <= col + COL_W'(1);
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end

  // Vertical: glyph line per line strobe, row per glyph wrap, frame restart
  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      gline  <= '0;
      row    <= '0;
      v_done <= 1'b0;
    end else if (line_end && !v_done) begin
      if (gline == GL_W'(CELL_H - 1)) begin
        gline <= '0;
        if (row == ROW_W'(ROWS - 1)) begin
          row    <= '0;
          v_done <= 1'b1;
        end else begin
          row <= row + ROW_W'(1);
        end
      end else begin
        gline <= gline + GL_W'(1);
      end
    end
  end

  assign cell_start = (sub == '0);
  assign fetch_ok   = !h_done && !v_done;

endmodule

// File: rtl/tc_shifter.sv
// Serialiser: loads one glyph line at the cell boundary, emits MSB first.
module tc_shifter #(
  parameter int GLYPH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               blank,
  input  logic               load,
  input  logic               valid,
  input  logic [GLYPH_W-1:0] glyph,
  output logic               pix
);

  logic [GLYPH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      pix <= 1'b0;
    end else begin
      if (load) sh <= valid ? glyph : '0;
      else      sh <= sh << 1;

      if (blank)     pix <= 1'b0;
      else if (load) pix <= valid & glyph[GLYPH_W-1];
      else           pix <= sh[GLYPH_W-2];
    end
  end

endmodule

// File: rtl/text_char_gen.sv
module text_char_gen
  import tc_pkg::*;
#(
  parameter int COLS    = 80,
  parameter int ROWS    = 40,
  parameter int CELL_H  = 12,
  parameter int GLYPH_W = 8,
  parameter int CODE_W  = 7
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    line_end,
  input  logic                                    frame_end,
  input  logic                                    blank,
  input  logic                                    scr_we,
  input  logic [$clog2(COLS*ROWS)-1:0]            scr_waddr,
  input  logic [CODE_W-1:0]                       scr_wdata,
  input  logic                                    font_we,
  input  logic [$clog2((1<<CODE_W)*CELL_H)-1:0]   font_waddr,
  input  logic [GLYPH_W-1:0]                      font_wdata,
  output logic                                    pix
);

  localparam int SCR_DEPTH  = COLS * ROWS;
  localparam int SCR_AW     = $clog2(SCR_DEPTH);
  localparam int FONT_DEPTH = (1 << CODE_W) * CELL_H;
  localparam int FONT_AW    = $clog2(FONT_DEPTH);
  localparam int COL_W      = $clog2(COLS);
  localparam int ROW_W      = $clog2(ROWS);
  localparam int GL_W       = $clog2(CELL_H);

  logic [COL_W-1:0]   col_q;
  logic [ROW_W-1:0]   row_q;
  logic [GL_W-1:0]    gline_q;
  logic               cell_start, fetch_ok, v_done_q;
  logic [SCR_AW-1:0]  scr_raddr;
  logic [CODE_W-1:0]  code_q;
  logic [FONT_AW-1:0] font_raddr;
  logic [GLYPH_W-1:0] glyph_q;
  tc_stage_t          st0, st1, st2;

  tc_raster_ctr #(
    .COLS(COLS), .ROWS(ROWS), .CELL_H(CELL_H), .GLYPH_W(GLYPH_W)
  ) u_ctr (
    .clk(clk), .rst(rst), .line_end(line_end), .frame_end(frame_end),
    .col(col_q), .row(row_q), .gline(gline_q),
    .cell_start(cell_start), .fetch_ok(fetch_ok), .v_done(v_done_q)
  );

  // Stage 0: screen address from the cell position
  assign scr_raddr = SCR_AW'(int'(row_q) * COLS + int'(col_q));

  tc_sdp_ram #(.DEPTH(SCR_DEPTH), .WIDTH(CODE_W), .AW(SCR_AW)) u_scr (
    .clk(clk), .we(scr_we), .waddr(scr_waddr), .wdata(scr_wdata),
    .raddr(scr_raddr), .rdata(code_q)
  );

  // Stage 1: glyph address from the fetched code and the current glyph line
  assign font_raddr = FONT_AW'(int'(code_q) * CELL_H + int'(gline_q));

  tc_sdp_ram #(.DEPTH(FONT_DEPTH), .WIDTH(GLYPH_W), .AW(FONT_AW)) u_font (
    .clk(clk), .we(font_we), .waddr(font_waddr), .wdata(font_wdata),
    .raddr(font_raddr), .rdata(glyph_q)
  );

  // Control travels alongside the two memory reads
  assign st0 = '{ld: cell_start, act: fetch_ok};

  always_ff @(posedge clk) begin
    if (rst) begin
      st1 <= '0;
      st2 <= '0;
    end else begin
      st1 <= st0;
      st2 <= st1;
    end
  end

  // Stage 2: serialise
  tc_shifter #(.GLYPH_W(GLYPH_W)) u_shift (
    .clk(clk), .rst(rst), .blank(blank),
    .load(st2.ld), .valid(st2.act), .glyph(glyph_q), .pix(pix)
  );

endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int COLS   = 80,
  parameter int ROWS   = 40,
  parameter int CELL_H = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      line_end,
  input logic                      frame_end,
  input logic                      blank,
  input logic                      pix,
  input logic                      v_done,
  input logic [$clog2(COLS)-1:0]   col,
  input logic [$clog2(ROWS)-1:0]   row,
  input logic [$clog2(CELL_H)-1:0] gline
);

  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int GL_W  = $clog2(CELL_H);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !pix)
    else $error("R1: pix high after reset cycle");

  p_col_range_r4: assert property (@(posedge clk) disable iff (rst)
    col <= COL_W'(COLS - 1))
    else $error("R4: column counter out of range");

  p_blank_zero_r5: assert property (@(posedge clk) disable iff (rst)
    blank |=> !pix)
    else $error("R5: pix high after blank");

  p_gline_step_r6: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_end && !v_done && gline != GL_W'(CELL_H - 1))
    |=> (gline == $past(gline) + GL_W'(1)) && (row == $past(row)))
    else $error("R6: glyph line did not step");

  p_row_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_end && !v_done && gline == GL_W'(CELL_H - 1)
     && row != ROW_W'(ROWS - 1))
    |=> (gline == '0) && (row == $past(row) + ROW_W'(1)))
    else $error("R6: row carry wrong");

  p_rows_done_r7: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_end && !v_done && gline == GL_W'(CELL_H - 1)
     && row == ROW_W'(ROWS - 1)) |=> v_done)
    else $error("R7: text area end not flagged");

  p_rows_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (v_done && !frame_end) |=> v_done)
    else $error("R7: left end-of-text state without frame strobe");

  p_frame_restart_r8: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (row == '0) && (gline == '0) && !v_done)
    else $error("R8: frame strobe did not restart");

endmodule

bind text_char_gen tc_checker #(.COLS(COLS), .ROWS(ROWS), .CELL_H(CELL_H)) u_chk (
  .clk(clk), .rst(rst), .line_end(line_end), .frame_end(frame_end),
  .blank(blank), .pix(pix), .v_done(v_done_q),
  .col(col_q), .row(row_q), .gline(gline_q)
);

// File: tb/sim_text_char_gen.sv
module sim_text_char_gen;

  logic        clk;
  logic        rst;
  logic        line_end, frame_end, blank;
  logic        scr_we;
  logic [11:0] scr_waddr;
  logic [6:0]  scr_wdata;
  logic        font_we;
  logic [10:0] font_waddr;
  logic [7:0]  font_wdata;
  logic        pix;

  logic [6:0] scr_m  [3200];
  logic [7:0] font_m [1536];
  logic       cap    [0:1023];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  text_char_gen u0 (
    .clk(clk), .rst(rst), .line_end(line_end), .frame_end(frame_end),
    .blank(blank), .scr_we(scr_we), .scr_waddr(scr_waddr), .scr_wdata(scr_wdata),
    .font_we(font_we), .font_waddr(font_waddr), .font_wdata(font_wdata),
    .pix(pix)
  );

  always #5 clk = ~clk;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      report();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] font_pat(input int i);
    return 8'((i * 73 + (i / 3) * 29 + 17) ^ (i * 5));
  endfunction

  function automatic int exp_pix(input int r, input int g, input int x);
    logic [6:0] c;
    logic [7:0] b;
    c = scr_m[r * 80 + x / 8];
    b = font_m[int'(c) * 12 + g];
    return int'(b[7 - (x % 8)]);
  endfunction

  task automatic scr_write(input int a, input logic [6:0] c);
    @(negedge clk);
    scr_we = 1; scr_waddr = 12'(a); scr_wdata = c;
    scr_m[a] = c;
    @(negedge clk);
    scr_we = 0;
  endtask

  task automatic font_write(input int a, input logic [7:0] b);
    @(negedge clk);
    font_we = 1; font_waddr = 11'(a); font_wdata = b;
    font_m[a] = b;
    @(negedge clk);
    font_we = 0;
  endtask

  // One scan line: strobe sampled at the next edge, then len-1 more clocks.
  // cap[j] holds pix after the j-th edge following the strobe edge.
  task automatic do_line(input int len, input bit fe, input int blo, input int bhi);
    @(negedge clk);
    line_end = 1; frame_end = fe;
    blank = (0 >= blo && 0 <= bhi);
    @(negedge clk);
    line_end = 0; frame_end = 0;
    cap[0] = pix;
    blank = (1 >= blo && 1 <= bhi);
    for (int j = 1; j < len; j++) begin
      @(negedge clk);
      cap[j] = pix;
      blank = ((j + 1) >= blo && (j + 1) <= bhi);
    end
    blank = 0;
  endtask

  task automatic check_line(input int r, input int g, input int nx,
                            input int blo, input int bhi, input string tag);
    for (int x = 0; x < nx; x++) begin
      int j = x + 3;
      int e = (j >= blo && j <= bhi) ? 0 : exp_pix(r, g, x);
      chk(tag, int'(cap[j]), e);
    end
  endtask

  task automatic check_zero(input int j0, input int j1, input string tag);
    for (int j = j0; j <= j1; j++) chk(tag, int'(cap[j]), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 during reset", int'(pix), 0);
    rst = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R1 before first line strobe", int'(pix), 0);
    end
  endtask

  task automatic t_load();
    for (int i = 0; i < 1536; i++) begin
      @(negedge clk);
      font_we = 1; font_waddr = 11'(i); font_wdata = font_pat(i);
      font_m[i] = font_pat(i);
    end
    for (int i = 0; i < 3200; i++) begin
      @(negedge clk);
      font_we = 0;
      scr_we = 1; scr_waddr = 12'(i); scr_wdata = 7'(i * 13 + (i / 80) * 5 + 1);
      scr_m[i] = 7'(i * 13 + (i / 80) * 5 + 1);
    end
    @(negedge clk);
    scr_we = 0;
    chk("R1 no output while loading", int'(pix), 0);
  endtask

  task automatic t_full_lines();
    for (int n = 0; n < 13; n++) begin
      do_line(650, n == 0, -1, -1);
      check_line(n / 12, n % 12, 640, -1, -1, "R2 R3 R6 full line");
      check_zero(643, 648, "R4 beyond last column");
    end
  endtask

  task automatic t_blank();
    do_line(650, 0, 100, 140);   // row 1, glyph line 1
    check_line(1, 1, 640, 100, 140, "R5 blank window");
  endtask

  task automatic t_host_write();
    logic [6:0] old_c, new_c;
    old_c = scr_m[83];
    new_c = old_c;
    for (int k = 1; k < 128; k++) begin
      new_c = 7'(int'(old_c) + k);
      if (font_m[int'(new_c) * 12 + 2] != font_m[int'(old_c) * 12 + 2]) break;
    end
    scr_write(83, new_c);
    do_line(650, 0, -1, -1);     // row 1, glyph line 2
    check_line(1, 2, 640, -1, -1, "R9 screen write shown");
  endtask

  task automatic t_font_load();
    int a;
    a = int'(scr_m[80]) * 12 + 3;
    font_write(a, ~font_m[a]);
    do_line(650, 0, -1, -1);     // row 1, glyph line 3
    check_line(1, 3, 640, -1, -1, "R10 font write shown");
  endtask

  task automatic t_row_sweep();
    for (int n = 0; n < 480; n++) begin
      do_line(24, n == 0, -1, -1);
      check_line(n / 12, n % 12, 16, -1, -1, "R6 row and glyph line sweep");
    end
    do_line(650, 0, -1, -1);
    check_zero(3, 649, "R7 line past text area");
    do_line(650, 0, -1, -1);
    check_zero(3, 649, "R7 second line past text area");
  endtask

  task automatic t_frame_restart();
    do_line(650, 1, -1, -1);
    check_line(0, 0, 640, -1, -1, "R8 restart after text area");
    for (int n = 1; n < 6; n++) do_line(24, 0, -1, -1);
    do_line(650, 1, -1, -1);
    check_line(0, 0, 640, -1, -1, "R8 restart mid frame");
  endtask

  initial begin
    clk = 0; rst = 1;
    line_end = 0; frame_end = 0; blank = 0;
    scr_we = 0; scr_waddr = '0; scr_wdata = '0;
    font_we = 0; font_waddr = '0; font_wdata = '0;
    t_reset();
    t_load();
    t_full_lines();
    t_blank();
    t_host_write();
    t_font_load();
    t_row_sweep();
    t_frame_restart();
    done = 1;
    report();
    $finish;
  end

endmodule